// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock-Stretch Control

This block is the bus side of a CPU-attached I2C slave. It synchronises the SCL and SDA inputs and detects Start and Stop conditions. It shifts in the 7-bit address and the data bytes, shifts out transmit bytes, and drives ACK or NACK on the ninth clock. When it needs the CPU it holds SCL low and raises a byte-complete interrupt. It releases SCL when the CPU writes the continue strobe.

Three configuration bits set how much the CPU must do. The first picks hardware or CPU address matching. The second picks whether SCL is held on every byte or only on the address byte. The third picks whether bytes that the slave ACKs on its own raise an interrupt. A further enable bit switches the whole slave on. With only the enable set, the slave holds SCL and interrupts on every byte, the address byte included. An optional Stop interrupt lets whole packets complete without the CPU handling each byte.

The CPU sees four 8-bit registers on a simple write-strobe / combinational-read port:

| reg_addr | Register |
|---|---|
| 0 | configuration |
| 1 | status / control |
| 2 | data |
| 3 | own address |

Top module: `i2c_stall_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0, and all four registers read 0.
- R2: With configuration bit 0 (enable) set and bit 1 (hardware compare) clear, the slave acts on the address byte once the 8th SCL falls. It holds SCL low (scl_oe=1) and sets status bit 0 (byte complete) and status bit 1 (address received). It copies the whole address byte, R/W bit included, into the data register and drives irq to 1.
- R3: Writing the status register with bit 7 (continue) set while SCL is held releases SCL within two clocks. On the following ninth clock the slave pulls SDA low if bit 2 of that write is 1 (ACK) and leaves SDA released if it is 0 (NACK). In status writes, a 0 in bit 0, 1 or 4 clears that flag and a 1 leaves it unchanged. After a NACK of a received byte the slave ignores the bus until the next Start.
- R4: With enable set and bits 1 and 2 of the configuration clear, every received data byte holds SCL, sets status bit 0 and drives irq. The data register then holds that byte.
- R5: With configuration bits 1 and 2 both set, the slave compares address bits 7:1 with own-address bits 6:0. On a match it ACKs the address, and then the data bytes, without holding SCL, and the data register holds the last byte received.
- R6: With hardware compare set, an address that does not match is NACKed with no hold and no interrupt. The rest of that transfer is ignored: no ACK and no change to the data register. A Stop that ends the ignored transfer leaves status bit 4 clear.
- R7: With hardware compare set and configuration bit 2 clear, SCL is held and irq raised at the address byte and at every data byte, even when configuration bit 3 (quiet) is set. The matched address is ACKed even if the continue write carries bit 2 = 0.
- R8: With hardware compare clear and configuration bit 2 set, SCL is held only at the address byte. Data bytes are ACKed on their own without a hold. Each such byte still sets status bit 0 and irq while configuration bit 3 is clear.
- R9: With configuration bit 3 set, a byte that is ACKed without a hold leaves status bit 0 clear and irq low.
- R10: A Stop that ends an addressed transfer sets status bit 4. irq follows that flag only when configuration bit 4 (Stop interrupt enable) is set.
- R11: When the address LSB is 1, the slave sends the data register MSB first after the address ACK, and status bit 3 reads 1 while it transmits. In the all-hold configuration, a master ACK on the ninth clock leads to a hold with irq before the next byte, sent after the CPU writes the continue strobe. A master NACK sets status bit 5 and ends the transfer with no hold.
- R12: Configuration bits 7:5 and own-address bit 7 read 0 whatever was written to them.
- R13: With configuration bit 0 clear, the slave never holds SCL, never drives SDA and raises no byte interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the slave with SYNC_STAGES=3. The deeper synchroniser adds input latency, and every hold, ACK drive and transmit bit must still settle inside one SCL half-period of ten system clocks. The master model honours clock stretching by waiting for the wired-AND SCL to rise. This makes it possible to check the CPU-paced hold and release in each combination of the address, hold and quiet bits. The same sequences cover transmit with master ACK and NACK, and a mismatched address followed by ignored bytes.

// File: rtl/i2c_stall_slave.sv
module i2c_stall_slave #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_RX, PH_TX} phase_t;

  logic [SYNC_STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q, scl_s, sda_s;
  logic start_c, stop_c, rise, fall, go_w, idle_w;

  logic en, hw, hold_addr_only, quiet, stop_ie;
  logic [6:0] own;
  logic [7:0] data_r, sh;
  logic byte_done, addr_flag, ack_bit, stop_flag, mnack;
  phase_t phase;
  logic [3:0] cnt;
  logic stall, gop, ackph, drv_low, txv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-2:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_s   = scl_p[SYNC_STAGES-1];
  assign sda_s   = sda_p[SYNC_STAGES-1];
  assign start_c = en & scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = en & scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign go_w    = reg_wr & (reg_addr == 2'd1) & reg_wdata[7];
  assign idle_w  = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {stop_ie, quiet, hold_addr_only, hw, en} <= '0;
      own <= '0; data_r <= '0; sh <= '0;
      byte_done <= 1'b0; addr_flag <= 1'b0; ack_bit <= 1'b0;
      stop_flag <= 1'b0; mnack <= 1'b0;
      phase <= PH_IDLE; cnt <= '0;
      stall <= 1'b0; gop <= 1'b0; ackph <= 1'b0; drv_low <= 1'b0; txv <= 1'b0;
    end else begin
      if (reg_wr)
        case (reg_addr)
          2'd0: {stop_ie, quiet, hold_addr_only, hw, en} <= reg_wdata[4:0];
          2'd1: begin
            byte_done <= byte_done & reg_wdata[0];
            addr_flag <= addr_flag & reg_wdata[1];
            ack_bit   <= reg_wdata[2];
            stop_flag <= stop_flag & reg_wdata[4];
          end
          2'd2: data_r <= reg_wdata;
          default: own <= reg_wdata[6:0];
        endcase

      if (gop) begin
        stall <= 1'b0;
        gop   <= 1'b0;
      end
      if (go_w && stall && !gop) begin
        gop <= 1'b1;
        if (ackph) drv_low <= (phase == PH_ADDR && hw) ? 1'b1 : reg_wdata[2];
        else begin
          sh  <= data_r;
          txv <= 1'b1;
        end
      end

      if (!en || start_c || stop_c) begin
        if (stop_c && phase != PH_IDLE) stop_flag <= 1'b1;
        phase <= (start_c && en) ? PH_ADDR : PH_IDLE;
        cnt <= '0;
        stall <= 1'b0; gop <= 1'b0; ackph <= 1'b0; drv_low <= 1'b0; txv <= 1'b0;
      end else if (phase != PH_IDLE && !stall) begin
        if (rise) begin
          if (!ackph && cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            if (phase != PH_TX) sh <= {sh[6:0], sda_s};
          end else if (ackph && phase == PH_TX) mnack <= sda_s;
        end else if (fall) begin
          if (ackph) begin
            ackph <= 1'b0; drv_low <= 1'b0; cnt <= '0;
            case (phase)
              PH_ADDR:
                if (!drv_low) phase <= PH_IDLE;
                else if (sh[0]) begin phase <= PH_TX; sh <= data_r; txv <= 1'b1; end
                else phase <= PH_RX;
              PH_RX: if (!drv_low) phase <= PH_IDLE;
              default:
                if (mnack) phase <= PH_IDLE;
                else if (!hold_addr_only) begin stall <= 1'b1; byte_done <= 1'b1; end
                else begin
                  sh <= data_r; txv <= 1'b1;
                  if (!quiet) byte_done <= 1'b1;
                end
            endcase
          end else if (cnt == 4'd8) begin
            ackph <= 1'b1;
            case (phase)
              PH_ADDR:
                if (hw && sh[7:1] != own) begin
                  phase <= PH_IDLE;
                  ackph <= 1'b0;
                end else begin
                  if (!hw) begin addr_flag <= 1'b1; data_r <= sh; end
                  if (!hw || !hold_addr_only) begin stall <= 1'b1; byte_done <= 1'b1; end
                  else begin
                    drv_low <= 1'b1;
                    if (!quiet) byte_done <= 1'b1;
                  end
                end
              PH_RX: begin
                data_r <= sh;
                if (!hold_addr_only) begin stall <= 1'b1; byte_done <= 1'b1; end
                else begin
                  drv_low <= 1'b1;
                  if (!quiet) byte_done <= 1'b1;
                end
              end
              default: txv <= 1'b0;
            endcase
          end else if (phase == PH_TX) sh <= {sh[6:0], 1'b0};
        end
      end
    end

  assign scl_oe = stall;
  assign sda_oe = (ackph & drv_low) | ((phase == PH_TX) & ~ackph & txv & ~sh[7]);
  assign irq    = byte_done | (stop_flag & stop_ie);

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {3'b000, stop_ie, quiet, hold_addr_only, hw, en};
      2'd1:    reg_rdata = {2'b00, mnack, stop_flag, phase == PH_TX, ack_bit, addr_flag, byte_done};
      2'd2:    reg_rdata = data_r;
      default: reg_rdata = {1'b0, own};
    endcase

endmodule

// File: rtl/i2c_stall_slave_chk.sv
module i2c_stall_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic gop,
  input logic start_c,
  input logic stop_c,
  input logic idle_w
);

  p_release_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> ($past(gop) || $past(start_c) || $past(stop_c) || $past(!en)));

  p_hold_raises_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> irq);

  p_idle_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (!sda_oe && !scl_oe));

  p_disabled_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!scl_oe && !sda_oe));

endmodule

bind i2c_stall_slave i2c_stall_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .gop(gop), .start_c(start_c), .stop_c(stop_c), .idle_w(idle_w)
);

// File: tb/test_i2c_stall_slave.sv
module test_i2c_stall_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_bus, sda_bus, scl_oe, sda_oe, irq;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_stall_slave #(.SYNC_STAGES(3)) i_i2c_stall_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; wait_high(); half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; wait_high(); half();
    sda_m = 1'b1; half();
  endtask

  task automatic m_bit(input logic b, output logic s);
    sda_m = b; half(); scl_m = 1'b1; wait_high(); half();
    s = sda_bus; scl_m = 1'b0; half();
  endtask

  task automatic m_send8(input logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
  endtask

  task automatic m_recv8(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic a;
    repeat (5) @(negedge clk);
    chk("R1 scl_oe", {7'd0, scl_oe}, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rreg(k[1:0], r); chk("R1 register reset", r, 8'h00);
    end

    // compatibility mode: CPU address compare, hold on every byte
    wreg(0, 8'hE1);
    rreg(0, r); chk("R12 config reserved", r, 8'h01);
    wreg(3, 8'hD2);
    rreg(3, r); chk("R12 own reserved", r, 8'h52);
    m_start(); m_send8(8'hA4);
    chk("R2 hold at address", {7'd0, scl_oe}, 8'h01);
    chk("R2 irq", {7'd0, irq}, 8'h01);
    rreg(1, r); chk("R2 status", r, 8'h03);
    rreg(2, r); chk("R2 data holds address", r, 8'hA4);
    wreg(1, 8'h84);
    chk("R3 released", {7'd0, scl_oe}, 8'h00);
    chk("R3 irq cleared", {7'd0, irq}, 8'h00);
    m_bit(1'b1, a); chk("R3 ack driven", {7'd0, a}, 8'h00);
    m_send8(8'h3C);
    chk("R4 hold at data", {7'd0, scl_oe}, 8'h01);
    chk("R4 irq", {7'd0, irq}, 8'h01);
    rreg(2, r); chk("R4 data", r, 8'h3C);
    wreg(1, 8'h84); m_bit(1'b1, a); chk("R4 ack", {7'd0, a}, 8'h00);
    m_send8(8'hF0);
    chk("R4 hold second byte", {7'd0, scl_oe}, 8'h01);
    wreg(1, 8'h80); m_bit(1'b1, a); chk("R3 nack", {7'd0, a}, 8'h01);
    m_send8(8'h0F); m_bit(1'b1, a);
    chk("R3 ignored after nack", {7'd0, a}, 8'h01);
    rreg(2, r); chk("R3 data kept after nack", r, 8'hF0);
    m_stop();
    rreg(1, r); chk("R10 no stop flag when idle", r, 8'h00);

    // hardware compare, address-only hold, quiet
    wreg(0, 8'h0F);
    m_start(); m_send8(8'hA4);
    chk("R5 no hold", {7'd0, scl_oe}, 8'h00);
    m_bit(1'b1, a); chk("R5 auto ack address", {7'd0, a}, 8'h00);
    chk("R9 no irq address", {7'd0, irq}, 8'h00);
    m_send8(8'h5A);
    chk("R5 no hold data", {7'd0, scl_oe}, 8'h00);
    m_bit(1'b1, a); chk("R5 auto ack data", {7'd0, a}, 8'h00);
    chk("R9 no irq data", {7'd0, irq}, 8'h00);
    rreg(2, r); chk("R5 data", r, 8'h5A);
    m_stop();
    rreg(1, r); chk("R10 stop flag", r, 8'h10);
    chk("R10 no stop irq when disabled", {7'd0, irq}, 8'h00);
    wreg(1, 8'h00);

    // mismatch
    m_start(); m_send8(8'hA6);
    chk("R6 no hold", {7'd0, scl_oe}, 8'h00);
    m_bit(1'b1, a); chk("R6 nack", {7'd0, a}, 8'h01);
    m_send8(8'h11); m_bit(1'b1, a);
    chk("R6 byte ignored", {7'd0, a}, 8'h01);
    chk("R6 no irq", {7'd0, irq}, 8'h00);
    rreg(2, r); chk("R6 data unchanged", r, 8'h5A);
    m_stop();
    rreg(1, r); chk("R6 no stop flag", r, 8'h00);

    // hardware compare, hold every byte, quiet has no effect
    wreg(0, 8'h0B);
    m_start(); m_send8(8'hA4);
    chk("R7 hold address", {7'd0, scl_oe}, 8'h01);
    chk("R7 irq address", {7'd0, irq}, 8'h01);
    rreg(1, r); chk("R7 status", r, 8'h01);
    wreg(1, 8'h80); m_bit(1'b1, a);
    chk("R7 address acked regardless", {7'd0, a}, 8'h00);
    m_send8(8'h77);
    chk("R7 hold data", {7'd0, scl_oe}, 8'h01);
    chk("R7 irq data", {7'd0, irq}, 8'h01);
    wreg(1, 8'h84); m_bit(1'b1, a); chk("R7 data ack", {7'd0, a}, 8'h00);
    m_stop(); wreg(1, 8'h00);

    // CPU compare, hold at address only
    wreg(0, 8'h05);
    m_start(); m_send8(8'hA4);
    chk("R8 hold address", {7'd0, scl_oe}, 8'h01);
    rreg(1, r); chk("R8 status address", r, 8'h03);
    wreg(1, 8'h84); m_bit(1'b1, a); chk("R8 address ack", {7'd0, a}, 8'h00);
    m_send8(8'h99);
    chk("R8 no hold data", {7'd0, scl_oe}, 8'h00);
    m_bit(1'b1, a); chk("R8 data auto ack", {7'd0, a}, 8'h00);
    chk("R8 irq data", {7'd0, irq}, 8'h01);
    rreg(1, r); chk("R8 status data", r, 8'h05);
    rreg(2, r); chk("R8 data", r, 8'h99);
    m_stop(); wreg(1, 8'h00);

    // stop interrupt
    wreg(0, 8'h1F);
    m_start(); m_send8(8'hA4); m_bit(1'b1, a);
    m_send8(8'h21); m_bit(1'b1, a);
    chk("R10 no irq before stop", {7'd0, irq}, 8'h00);
    m_stop();
    chk("R10 stop irq", {7'd0, irq}, 8'h01);
    rreg(1, r); chk("R10 stop status", r, 8'h10);
    wreg(1, 8'h00);
    chk("R10 stop irq cleared", {7'd0, irq}, 8'h00);

    // transmit in compatibility mode
    wreg(0, 8'h01);
    m_start(); m_send8(8'hA5);
    chk("R11 hold read address", {7'd0, scl_oe}, 8'h01);
    rreg(1, r); chk("R11 status address", r, 8'h03);
    wreg(2, 8'hC3); wreg(1, 8'h84);
    m_bit(1'b1, a); chk("R11 address ack", {7'd0, a}, 8'h00);
    m_recv8(r); chk("R11 first byte", r, 8'hC3);
    rreg(1, r); chk("R11 transmit status", r, 8'h0C);
    m_bit(1'b0, a);
    chk("R11 hold after master ack", {7'd0, scl_oe}, 8'h01);
    chk("R11 irq after master ack", {7'd0, irq}, 8'h01);
    wreg(2, 8'h5E); wreg(1, 8'h84);
    m_recv8(r); chk("R11 second byte", r, 8'h5E);
    m_bit(1'b1, a);
    chk("R11 no hold after master nack", {7'd0, scl_oe}, 8'h00);
    rreg(1, r); chk("R11 master nack status", r, 8'h24);
    m_stop();

    // disabled
    wreg(0, 8'h00);
    m_start(); m_send8(8'hA4);
    chk("R13 no hold", {7'd0, scl_oe}, 8'h00);
    m_bit(1'b1, a); chk("R13 no ack", {7'd0, a}, 8'h01);
    chk("R13 no irq", {7'd0, irq}, 8'h00);
    m_stop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule